// File: doc/BRIEF.md
# Scalar Half-Precision Reciprocal Square-Root Unit

This unit estimates 1/sqrt(x) for one IEEE half-precision value, the low 16-bit lane of the second vector source. It writes the estimate into the low lane of a 128-bit result. The other 112 bits of the result come straight from the first source. A per-operation write-mask bit and a mask-enable flag decide whether the low lane takes the estimate. When the lane is masked off, a zeroing/merge flag picks between clearing it and keeping the previous destination lane, which is given as a separate 16-bit input.

The estimate comes from a seed table and one fixed-point Newton-Raphson step. The seed table is indexed by the parity of the unbiased exponent and the six leading fraction bits. Subnormal inputs are normalized first. The result is rounded into a normal half-precision value, and special operands are mapped to fixed codes.

The datapath has three register stages and no backpressure. A new operation may enter on every cycle.

Top module: `rsq_fp16_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 3 clock edges. Every accepted operation produces one result on that cycle, including back-to-back operations and operations with gaps between them.
- R2: `result[127:16]` equals the `src_a_hi` value presented with the same operation, whatever the mask settings.
- R3: For a positive normal input, the low lane is a positive normal half-precision value. Its relative error against the exact 1/sqrt(x) is below 2^-11 + 2^-14.
- R4: An input of +0 (0x0000) gives +Inf (0x7C00), and -0 (0x8000) gives -Inf (0xFC00).
- R5: An input of +Inf (0x7C00) gives +0 (0x0000).
- R6: Any input with sign bit 15 set that is not a zero and not a NaN, -Inf included, gives the default quiet NaN 0x7E00.
- R7: A NaN input (exponent field bits 14:10 all ones, fraction nonzero) is returned with bit 9 set and all other bits unchanged.
- R8: When `mask_en` is 0, or `mask_bit` is 1, the low lane carries the computed value of R3 to R7 (and R12).
- R9: When `mask_en` is 1, `mask_bit` is 0 and `zero_mode` is 1, the low lane is 0x0000.
- R10: When `mask_en` is 1, `mask_bit` is 0 and `zero_mode` is 0, the low lane equals the `dst_prev_lo` value presented with that operation.
- R11: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R12: A positive subnormal input (exponent field 0, fraction nonzero) gives a positive normal result that meets the same error bound as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| src_a_hi | input | 112 | Upper 112 bits of the first source, copied into result[127:16] |
| src_b_lo | input | 16 | Low half-precision element of the second source, the operand |
| dst_prev_lo | input | 16 | Previous destination low lane, kept in merge mode |
| mask_en | input | 1 | 1 = write-mask applies, 0 = low lane always written |
| mask_bit | input | 1 | Write-mask bit for the low lane |
| zero_mode | input | 1 | 1 = zero a masked-off lane, 0 = merge previous value |
| out_valid | output | 1 | Result valid, three cycles after in_valid |
| result | output | 128 | Destination vector |

## Verification
The bench sweeps every one of the 65536 operand codes through the unit back to back and checks each result against a real-valued 1/sqrt. A badly placed seed index or a truncating Newton step would push inputs near the interval ends past the error bound. Inputs just below 4.0 and exactly 1.0 test the normalization: the refined value can dip under one half or round up to 2.0, and a design without the extra shift or the exponent carry would produce off-by-one exponents there. The subnormal sweep exposes a leading-zero count or exponent offset that is off by one, because the result would then be wrong by a factor of sqrt(2). A masked section rotates through all mask, zero and merge combinations, with gaps in `in_valid`, under changing upper-lane data. This catches a lane select that reads the wrong stage's control, and an upper copy taken from the wrong operand.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int H_W     = 16;
  localparam int EXP_W   = 5;
  localparam int MAN_W   = 10;
  localparam int BIAS    = 15;
  localparam int XQ_W    = 13;
  localparam int XQ_FRAC = 11;
  localparam int K_W     = 7;

  localparam logic [H_W-1:0] QNAN_DEFAULT = 16'h7E00;
  localparam logic [H_W-1:0] QUIET_BIT    = 16'h0200;

  typedef struct packed {
    logic                  wr;
    logic                  zm;
    logic [H_W-1:0]        prev;
    logic                  special;
    logic [H_W-1:0]        spec;
    logic signed [K_W-1:0] k;
  } lane_ctl_t;

  function automatic longint unsigned isqrt(longint unsigned v);
    longint unsigned r;
    longint unsigned b;
    longint unsigned rem;
    r   = 0;
    rem = v;
    b   = 64'h1 << 62;
    while (b > rem) b = b >> 2;
    while (b != 0) begin
      if (rem >= r + b) begin
        rem = rem - (r + b);
        r   = (r >> 1) + b;
      end else begin
        r = r >> 1;
      end
      b = b >> 2;
    end
    return r;
  endfunction

  // Seed for the interval midpoint: idx = {exponent parity, top iw fraction bits}
  function automatic longint unsigned seed_calc(int idx, int iw, int fw);
    longint unsigned odd;
    longint unsigned m;
    longint unsigned den;
    longint unsigned num;
    odd = longint'((idx >> iw) & 1);
    m   = longint'(idx & ((1 << iw) - 1));
    den = ((longint'(1) << (iw + 1)) + 2 * m + 1) << odd;
    num = longint'(1) << (2 * fw + iw + 1);
    return isqrt(num / den);
  endfunction

endpackage

// File: rtl/rsq_front.sv
module rsq_front #(
  parameter int FRAC_W = 20,
  parameter int IDX_W  = 6
) (
  input  logic [rsq_pkg::H_W-1:0]         h,
  output logic                            special,
  output logic [rsq_pkg::H_W-1:0]         spec,
  output logic [rsq_pkg::XQ_W-1:0]        xq,
  output logic [FRAC_W-1:0]               y0,
  output logic signed [rsq_pkg::K_W-1:0]  k
);
  import rsq_pkg::*;

  localparam int ROM_N = 1 << (IDX_W + 1);

  logic [FRAC_W-1:0] rom [ROM_N];

  for (genvar g = 0; g < ROM_N; g++) begin : g_seed
    localparam logic [FRAC_W-1:0] SEED = FRAC_W'(seed_calc(g, IDX_W, FRAC_W));
    assign rom[g] = SEED;
  end

  logic                  sgn;
  logic [EXP_W-1:0]      ex;
  logic [MAN_W-1:0]      fr;
  logic                  is_nan, is_inf, is_zero, is_sub;
  logic [3:0]            lz;
  logic                  found;
  logic [MAN_W:0]        mant;
  logic signed [K_W-1:0] ue;
  logic [IDX_W:0]        idx;

  assign sgn = h[H_W-1];
  assign ex  = h[H_W-2 -: EXP_W];
  assign fr  = h[MAN_W-1:0];

  assign is_nan  = (ex == '1) && (fr != '0);
  assign is_inf  = (ex == '1) && (fr == '0);
  assign is_zero = (ex == '0) && (fr == '0);
  assign is_sub  = (ex == '0) && (fr != '0);

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = MAN_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (fr[i]) found = 1'b1;
        else       lz    = lz + 4'd1;
      end
    end
  end

  always_comb begin
    special = 1'b1;
    spec    = '0;
    if (is_nan)       spec = h | QUIET_BIT;
    else if (is_zero) spec = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else if (sgn)     spec = QNAN_DEFAULT;
    else if (is_inf)  spec = '0;
    else              special = 1'b0;
  end

  always_comb begin
    if (is_sub) begin
      mant = {1'b0, fr} << (lz + 4'd1);
      ue   = -7'sd15 - $signed({3'b000, lz});
    end else begin
      mant = {1'b1, fr};
      ue   = $signed({2'b00, ex}) - 7'sd15;
    end
  end

  assign k   = ue >>> 1;
  assign idx = {ue[0], mant[MAN_W-1 -: IDX_W]};
  assign y0  = rom[idx];
  assign xq  = ue[0] ? {mant, 2'b00} : {1'b0, mant, 1'b0};

endmodule

// File: rtl/rsq_refine.sv
module rsq_refine #(
  parameter int FRAC_W = 20
) (
  input  logic [FRAC_W-1:0]          y0,
  input  logic [rsq_pkg::XQ_W-1:0]   xq,
  output logic [FRAC_W+1:0]          tm
);
  import rsq_pkg::*;

  localparam int SQ_W = 2 * FRAC_W;
  localparam int P_W  = FRAC_W + XQ_W;
  localparam logic [FRAC_W+1:0] THREE = (FRAC_W + 2)'(3) << FRAC_W;

  logic [SQ_W-1:0]   sq;
  logic [FRAC_W-1:0] sqt;
  logic [P_W-1:0]    p;
  logic [FRAC_W+1:0] t;

  assign sq  = {{FRAC_W{1'b0}}, y0} * {{FRAC_W{1'b0}}, y0};
  assign sqt = FRAC_W'(sq >> FRAC_W);
  assign p   = {{XQ_W{1'b0}}, sqt} * {{FRAC_W{1'b0}}, xq};
  assign t   = (FRAC_W + 2)'(p >> XQ_FRAC);
  assign tm  = THREE - t;

endmodule

// File: rtl/rsq_back.sv
module rsq_back #(
  parameter int FRAC_W = 20
) (
  input  logic [FRAC_W-1:0]        y0,
  input  logic [FRAC_W+1:0]        tm,
  input  rsq_pkg::lane_ctl_t       ctl,
  output logic [rsq_pkg::H_W-1:0]  lane
);
  import rsq_pkg::*;

  localparam int PR_W = 2 * FRAC_W + 2;

  logic [PR_W-1:0]     prod;
  logic [FRAC_W:0]     y1;
  logic [MAN_W:0]      sel;
  logic [1:0]          c;
  logic [MAN_W:0]      sum;
  logic                carry;
  logic [MAN_W-1:0]    frac;
  logic signed [7:0]   ebi;
  logic [H_W-1:0]      num;
  logic [H_W-1:0]      comp;

  assign prod = {{(FRAC_W + 2){1'b0}}, y0} * {{FRAC_W{1'b0}}, tm};
  assign y1   = (FRAC_W + 1)'(prod >> (FRAC_W + 1));

  always_comb begin
    if (y1[FRAC_W]) begin
      c   = 2'd0;
      sel = '0;
    end else if (y1[FRAC_W-1]) begin
      c   = 2'd1;
      sel = (MAN_W + 1)'(y1 >> (FRAC_W - 12));
    end else begin
      c   = 2'd2;
      sel = (MAN_W + 1)'(y1 >> (FRAC_W - 13));
    end
  end

  assign sum   = {1'b0, sel[MAN_W:1]} + {{MAN_W{1'b0}}, sel[0]};
  assign carry = sum[MAN_W];
  assign frac  = carry ? '0 : sum[MAN_W-1:0];
  assign ebi   = 8'sd15 - {ctl.k[K_W-1], ctl.k} - $signed({6'b0, c})
                 + $signed({7'b0, carry});
  assign num   = {1'b0, ebi[EXP_W-1:0], frac};
  assign comp  = ctl.special ? ctl.spec : num;

  always_comb begin
    if (ctl.wr)      lane = comp;
    else if (ctl.zm) lane = '0;
    else             lane = ctl.prev;
  end

endmodule

// File: rtl/rsq_fp16_unit.sv
module rsq_fp16_unit #(
  parameter int VEC_W  = 128,
  parameter int FRAC_W = 20,
  parameter int IDX_W  = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic [VEC_W-rsq_pkg::H_W-1:0]   src_a_hi,
  input  logic [rsq_pkg::H_W-1:0]         src_b_lo,
  input  logic [rsq_pkg::H_W-1:0]         dst_prev_lo,
  input  logic                            mask_en,
  input  logic                            mask_bit,
  input  logic                            zero_mode,
  output logic                            out_valid,
  output logic [VEC_W-1:0]                result
);
  import rsq_pkg::*;

  localparam int UP_W = VEC_W - H_W;

  // stage 1 next state
  logic                  f_special;
  logic [H_W-1:0]        f_spec;
  logic [XQ_W-1:0]       f_xq;
  logic [FRAC_W-1:0]     f_y0;
  logic signed [K_W-1:0] f_k;
  lane_ctl_t             ctl_d;

  rsq_front #(.FRAC_W(FRAC_W), .IDX_W(IDX_W)) u_front (
    .h       (src_b_lo),
    .special (f_special),
    .spec    (f_spec),
    .xq      (f_xq),
    .y0      (f_y0),
    .k       (f_k)
  );

  always_comb begin
    ctl_d.wr      = !mask_en || mask_bit;
    ctl_d.zm      = zero_mode;
    ctl_d.prev    = dst_prev_lo;
    ctl_d.special = f_special;
    ctl_d.spec    = f_spec;
    ctl_d.k       = f_k;
  end

  logic              s1_v;
  lane_ctl_t         s1_ctl;
  logic [UP_W-1:0]   s1_up;
  logic [XQ_W-1:0]   s1_xq;
  logic [FRAC_W-1:0] s1_y0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ctl <= '0;
      s1_up  <= '0;
      s1_xq  <= '0;
      s1_y0  <= '0;
    end else if (in_valid) begin
      s1_ctl <= ctl_d;
      s1_up  <= src_a_hi;
      s1_xq  <= f_xq;
      s1_y0  <= f_y0;
    end
  end

  // stage 2
  logic [FRAC_W+1:0] r_tm;

  rsq_refine #(.FRAC_W(FRAC_W)) u_refine (
    .y0 (s1_y0),
    .xq (s1_xq),
    .tm (r_tm)
  );

  logic              s2_v;
  lane_ctl_t         s2_ctl;
  logic [UP_W-1:0]   s2_up;
  logic [FRAC_W-1:0] s2_y0;
  logic [FRAC_W+1:0] s2_tm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_v <= 1'b0;
    else        s2_v <= s1_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_ctl <= '0;
      s2_up  <= '0;
      s2_y0  <= '0;
      s2_tm  <= '0;
    end else if (s1_v) begin
      s2_ctl <= s1_ctl;
      s2_up  <= s1_up;
      s2_y0  <= s1_y0;
      s2_tm  <= r_tm;
    end
  end

  // stage 3
  logic [H_W-1:0]   lane_d;
  logic [VEC_W-1:0] res_d;
  logic             out_v_q;
  logic [VEC_W-1:0] res_q;

  rsq_back #(.FRAC_W(FRAC_W)) u_back (
    .y0   (s2_y0),
    .tm   (s2_tm),
    .ctl  (s2_ctl),
    .lane (lane_d)
  );

  assign res_d = {s2_up, lane_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_v_q <= 1'b0;
    else        out_v_q <= s2_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (s2_v) res_q <= res_d;
  end

  assign out_valid = out_v_q;
  assign result    = res_q;

endmodule

// File: rtl/rsq_fp16_chk.sv
module rsq_fp16_chk #(
  parameter int VEC_W = 128
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [VEC_W-17:0]     src_a_hi,
  input logic [15:0]           src_b_lo,
  input logic [15:0]           dst_prev_lo,
  input logic                  mask_en,
  input logic                  mask_bit,
  input logic                  zero_mode,
  input logic                  out_valid,
  input logic [VEC_W-1:0]      result
);
  logic [1:0] since_rst;
  logic       hist_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign hist_ok = (since_rst == 2'd3);

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_ok |-> (out_valid == $past(in_valid, 3)));

  // R2
  upper_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(in_valid, 3)) |-> (result[VEC_W-1:16] == $past(src_a_hi, 3)));

  // R9
  zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(in_valid && mask_en && !mask_bit && zero_mode, 3))
      |-> (result[15:0] == 16'h0000));

  // R10
  merge_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(in_valid && mask_en && !mask_bit && !zero_mode, 3))
      |-> (result[15:0] == $past(dst_prev_lo, 3)));

  // R3
  pos_finite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(in_valid && (!mask_en || mask_bit) && !src_b_lo[15]
                      && (src_b_lo[14:10] != 5'h1f) && (src_b_lo[14:0] != 15'h0), 3))
      |-> (!result[15] && (result[14:10] != 5'h1f) && (result[14:10] != 5'h00)));

endmodule

bind rsq_fp16_unit rsq_fp16_chk #(.VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .src_a_hi    (src_a_hi),
  .src_b_lo    (src_b_lo),
  .dst_prev_lo (dst_prev_lo),
  .mask_en     (mask_en),
  .mask_bit    (mask_bit),
  .zero_mode   (zero_mode),
  .out_valid   (out_valid),
  .result      (result)
);

// File: tb/tb_rsq_fp16_unit.sv
module tb_rsq_fp16_unit;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [111:0] src_a_hi;
  logic [15:0]  src_b_lo;
  logic [15:0]  dst_prev_lo;
  logic         mask_en;
  logic         mask_bit;
  logic         zero_mode;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rsq_fp16_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a_hi(src_a_hi),
    .src_b_lo(src_b_lo), .dst_prev_lo(dst_prev_lo), .mask_en(mask_en),
    .mask_bit(mask_bit), .zero_mode(zero_mode), .out_valid(out_valid),
    .result(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic         v;
    logic [15:0]  b;
    logic [111:0] up;
    logic [15:0]  prev;
    logic         en;
    logic         mb;
    logic         zm;
  } stim_t;

  stim_t hist [3];

  function automatic real h2r(logic [15:0] h);
    int e;
    int f;
    e = int'(h[14:10]);
    f = int'(h[9:0]);
    if (e == 0) return real'(f) * (2.0 ** (-24.0));
    return (1024.0 + real'(f)) * (2.0 ** (real'(e) - 25.0));
  endfunction

  task automatic expect_eq(string tag, logic [15:0] act, logic [15:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: lane actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic check_value(string pre, logic [15:0] b, logic [15:0] lane);
    logic [4:0] e;
    logic [9:0] f;
    real        ref_v;
    real        got;
    real        rel;
    real        bound;
    e = b[14:10];
    f = b[9:0];
    bound = 2.0 ** (-11.0) + 2.0 ** (-14.0);
    if (e == 5'h1f && f != 0)            expect_eq({pre, "R7 nan"}, lane, b | 16'h0200);
    else if (e == 0 && f == 0)           expect_eq({pre, "R4 zero"}, lane, {b[15], 15'h7C00});
    else if (b[15])                      expect_eq({pre, "R6 negative"}, lane, 16'h7E00);
    else if (e == 5'h1f)                 expect_eq({pre, "R5 inf"}, lane, 16'h0000);
    else begin
      checks++;
      ref_v = 1.0 / $sqrt(h2r(b));
      got   = h2r(lane);
      rel   = (got - ref_v) / ref_v;
      if (rel < 0.0) rel = -rel;
      if (lane[15] || lane[14:10] == 5'h1f || lane[14:10] == 5'h00 || !(rel < bound)) begin
        errors++;
        if (e == 0)
          $display("FAIL %sR12 subnormal in %h: actual %h (rel %e) expected %e within %e",
                   pre, b, lane, rel, ref_v, bound);
        else
          $display("FAIL %sR3 normal in %h: actual %h (rel %e) expected %e within %e",
                   pre, b, lane, rel, ref_v, bound);
      end
    end
  endtask

  task automatic check_out(stim_t h);
    checks++;
    if (out_valid !== h.v) begin
      errors++;
      $display("FAIL R1: out_valid actual %b expected %b", out_valid, h.v);
    end
    if (h.v) begin
      checks++;
      if (result[127:16] !== h.up) begin
        errors++;
        $display("FAIL R2: upper actual %h expected %h", result[127:16], h.up);
      end
      if (h.en && !h.mb) begin
        if (h.zm) expect_eq("R9 zeroing", result[15:0], 16'h0000);
        else      expect_eq("R10 merge", result[15:0], h.prev);
      end else begin
        check_value(h.en ? "R8 mask set, " : "R8 mask off, ", h.b, result[15:0]);
      end
    end
  endtask

  task automatic step(stim_t s);
    @(negedge clk);
    check_out(hist[2]);
    hist[2] = hist[1];
    hist[1] = hist[0];
    hist[0] = s;
    in_valid    = s.v;
    src_b_lo    = s.b;
    src_a_hi    = s.up;
    dst_prev_lo = s.prev;
    mask_en     = s.en;
    mask_bit    = s.mb;
    zero_mode   = s.zm;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    stim_t s;
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    src_a_hi    = '0;
    src_b_lo    = '0;
    dst_prev_lo = '0;
    mask_en     = 1'b0;
    mask_bit    = 1'b0;
    zero_mode   = 1'b0;
    for (int i = 0; i < 3; i++) hist[i] = '0;

    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R11: reset out_valid %b result %h expected 0 and 0", out_valid, result);
    end
    rst_n = 1'b1;

    // idle cycles after reset: no valid output
    for (int i = 0; i < 4; i++) step('0);

    // R3 R4 R5 R6 R7 R12: every operand code, back to back, lane always written
    for (int i = 0; i < 65536; i++) begin
      s.v    = 1'b1;
      s.b    = 16'(i);
      s.up   = {7{16'(i * 37 + 5)}};
      s.prev = ~16'(i);
      s.en   = 1'b0;
      s.mb   = 1'b0;
      s.zm   = i[0];
      step(s);
    end

    // R1 R2 R8 R9 R10: rotating mask modes with gaps in valid
    for (int i = 0; i < 4000; i++) begin
      s.v    = (i % 7) != 6;
      s.b    = 16'(i * 97 + 3);
      s.up   = {7{16'(i * 131 + 11)}} ^ {112{i[3]}};
      s.prev = 16'(i * 53 + 1);
      case (i % 4)
        0: begin s.en = 1'b0; s.mb = 1'b0; s.zm = 1'b1; end
        1: begin s.en = 1'b1; s.mb = 1'b1; s.zm = i[2]; end
        2: begin s.en = 1'b1; s.mb = 1'b0; s.zm = 1'b1; end
        default: begin s.en = 1'b1; s.mb = 1'b0; s.zm = 1'b0; end
      endcase
      step(s);
    end

    for (int i = 0; i < 4; i++) step('0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule